// File: doc/BRIEF.md
# On-Chip RAM Window Decoder

This block maps a 64 MB CPU address window onto a local byte-addressable data RAM. The RAM holds two 4 KB pages. Each page stands in for one half of an operand-cache data array that has been switched into RAM mode. Every access carries an address, a direction and a size: byte, word, long or a 32-byte burst. The block decodes whether the address falls inside the window, picks the backing page and checks that the access is legal. Legal reads and writes go to the internal synchronous RAM. Narrow reads come back sign-extended to 32 bits.

Three mode inputs control the mapping:

- `cache_en_i` and `ram_mode_i` together enable the window. If either is low, every in-window access is reported as an error.
- `split_mode_i` picks how 4 KB pages are assigned to the two storage pages.
  - Interleaved (input low): the window repeats in groups of four pages. The first two pages of each group map to storage page 0 and the next two map to storage page 1.
  - Split (input high): the lower half of the window maps to storage page 0 and the upper half maps to storage page 1.

The offset within a page is always address bits 11:0. An access outside the window is ignored, so that another decoder can claim it.

Top module: `ocram_window`

## Requirements
- R1: An access whose address bits 31:26 differ from 6'b011111 (outside 0x7C000000..0x7FFFFFFF) leaves `sel_o`, `ack_o` and `err_o` low and does not modify the RAM.
- R2: An in-window access while `cache_en_i` or `ram_mode_i` is low raises `err_o` and `sel_o` and does not modify the RAM.
- R3: With `split_mode_i` low, the storage page is address bit 13: pages 4k and 4k+1 map to page 0, and pages 4k+2 and 4k+3 map to page 1.
- R4: With `split_mode_i` high, the storage page is address bit 25, and bit 13 has no effect on where the access lands.
- R5: The offset within a page is address bits 11:0. Both modes address the same storage, so data written in one mode can be read back in the other at the matching page and offset.
- R6: `size_i` encodes the access size as 0 = byte, 1 = word, 2 = long, 3 = burst. Byte lanes are little-endian: address offset +k holds bits 8k+7:8k of a long.
- R7: Byte and word reads return the addressed value sign-extended to 32 bits in `rdata_o`.
- R8: A burst moves the 32 bytes starting at the page offset. Byte k of `bwdata_i` or `brdata_o` sits at bits 8k+7:8k.
- R9: An in-window access is misaligned if it is a word at an odd address, a long at an address not a multiple of 4, or a burst at an address not a multiple of 32. A misaligned access raises `err_o` and does not modify the RAM.
- R10: `sel_o`, `ack_o` and `err_o` are one-cycle pulses in the cycle after the request. Read data is valid alongside `ack_o`. `ack_o` and `err_o` never assert together, and all three stay low in a cycle that follows no request.
- R11: After reset, `sel_o`, `ack_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 burst |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data for byte, word and long accesses (low bits used) |
| bwdata_i | input | 256 | Burst write data, byte k at bits 8k+7:8k |
| cache_en_i | input | 1 | Cache enable |
| ram_mode_i | input | 1 | Cache data array used as RAM |
| split_mode_i | input | 1 | 1 = half-window split, 0 = four-page interleave |
| sel_o | output | 1 | Previous request fell inside the window |
| ack_o | output | 1 | Previous request completed |
| err_o | output | 1 | Previous request was unmapped or misaligned |
| rdata_o | output | 32 | Read result for byte, word and long reads, sign-extended |
| brdata_o | output | 256 | Burst read result |

## Verification
A wrong page bit or offset inside the decoder shows up as wrong read data. The bench writes a known pattern at one address, then reads it back through aliased addresses and from the other page-mapping mode, so a fault like this appears on `rdata_o` at the read that follows the misplaced write. A fault in the enable or alignment logic either asserts `err_o` in the cycle after the request, or leaves RAM contents changed. The bench rereads a known location after each group of rejected accesses, so the damage is caught at that reread. Lane and sign-extension faults corrupt only part of the read word. Reading each byte, word and long of a mixed-sign pattern exposes them on the first narrow read.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_BURST = 2'd3
  } ocw_size_e;
endpackage

// File: rtl/ocw_decode.sv
module ocw_decode #(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_BITS = 26,
  parameter logic [31:0] WIN_BASE = 32'h7C00_0000,
  parameter int          PAGE_AW  = 12,
  parameter int          LANE_W   = 5,
  localparam int         LINE_AW  = PAGE_AW - LANE_W + 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic               cache_en_i,
  input  logic               ram_mode_i,
  input  logic               split_mode_i,
  output logic               in_win_o,
  output logic               ok_o,
  output logic [LINE_AW-1:0] line_o,
  output logic [LANE_W-1:0]  lane_o
);
  import ocw_pkg::*;

  localparam int ILV_BIT = PAGE_AW + 1;
  localparam int MID_BIT = WIN_BITS - 1;

  ocw_size_e sz;
  logic      misal;
  logic      page;
  logic      unused_addr;

  assign sz       = ocw_size_e'(size_i);
  assign in_win_o = (addr_i[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
  assign page     = split_mode_i ? addr_i[MID_BIT] : addr_i[ILV_BIT];
  assign line_o   = {page, addr_i[PAGE_AW-1:LANE_W]};
  assign lane_o   = addr_i[LANE_W-1:0];

  always_comb begin
    unique case (sz)
      SZ_BYTE:  misal = 1'b0;
      SZ_WORD:  misal = addr_i[0];
      SZ_LONG:  misal = |addr_i[1:0];
      default:  misal = |addr_i[LANE_W-1:0];
    endcase
  end

  assign ok_o        = in_win_o && cache_en_i && ram_mode_i && !misal;
  assign unused_addr = ^addr_i;
endmodule

// File: rtl/ocw_wpack.sv
module ocw_wpack #(
  parameter  int LINE_BYTES = 32,
  localparam int LANE_W     = $clog2(LINE_BYTES),
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic [1:0]            size_i,
  input  logic [LANE_W-1:0]     lane_i,
  input  logic [31:0]           wdata_i,
  input  logic [LINE_W-1:0]     bwdata_i,
  output logic [LINE_BYTES-1:0] be_o,
  output logic [LINE_W-1:0]     line_o
);
  import ocw_pkg::*;

  localparam logic [LINE_BYTES-1:0] ONE = LINE_BYTES'(1);

  always_comb begin
    unique case (ocw_size_e'(size_i))
      SZ_BYTE: begin
        be_o   = ONE << lane_i;
        line_o = {LINE_BYTES{wdata_i[7:0]}};
      end
      SZ_WORD: begin
        be_o   = (ONE * 3) << lane_i;
        line_o = {(LINE_BYTES/2){wdata_i[15:0]}};
      end
      SZ_LONG: begin
        be_o   = (ONE * 15) << lane_i;
        line_o = {(LINE_BYTES/4){wdata_i}};
      end
      default: begin
        be_o   = '1;
        line_o = bwdata_i;
      end
    endcase
  end
endmodule

// File: rtl/ocw_rext.sv
module ocw_rext #(
  parameter  int LINE_BYTES = 32,
  localparam int LANE_W     = $clog2(LINE_BYTES),
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic [1:0]        size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [31:0]       rdata_o
);
  import ocw_pkg::*;

  logic [LINE_W-1:0] shifted;
  logic [LINE_W-33:0] unused_hi;

  assign shifted   = line_i >> {lane_i, 3'b000};
  assign unused_hi = shifted[LINE_W-1:32];

  always_comb begin
    unique case (ocw_size_e'(size_i))
      SZ_BYTE: rdata_o = {{24{shifted[7]}}, shifted[7:0]};
      SZ_WORD: rdata_o = {{16{shifted[15]}}, shifted[15:0]};
      default: rdata_o = shifted[31:0];
    endcase
  end
endmodule

// File: rtl/ocw_ram.sv
module ocw_ram #(
  parameter  int LINE_BYTES = 32,
  parameter  int LINE_AW    = 8,
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int DEPTH      = 1 << LINE_AW
) (
  input  logic                  clk,
  input  logic                  we_i,
  input  logic                  re_i,
  input  logic [LINE_AW-1:0]    addr_i,
  input  logic [LINE_BYTES-1:0] be_i,
  input  logic [LINE_W-1:0]     wline_i,
  output logic [LINE_W-1:0]     rline_o
);
  logic [LINE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (be_i[b]) mem[addr_i][b*8 +: 8] <= wline_i[b*8 +: 8];
      end
    end
    if (re_i) rline_o <= mem[addr_i];
  end
endmodule

// File: rtl/ocram_window.sv
module ocram_window #(
  parameter  int          ADDR_W     = 32,
  parameter  int          WIN_BITS   = 26,
  parameter  logic [31:0] WIN_BASE   = 32'h7C00_0000,
  parameter  int          PAGE_AW    = 12,
  parameter  int          LINE_BYTES = 32,
  localparam int          LANE_W     = $clog2(LINE_BYTES),
  localparam int          LINE_W     = LINE_BYTES * 8,
  localparam int          LINE_AW    = PAGE_AW - LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [LINE_W-1:0] bwdata_i,
  input  logic              cache_en_i,
  input  logic              ram_mode_i,
  input  logic              split_mode_i,
  output logic              sel_o,
  output logic              ack_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic [LINE_W-1:0] brdata_o
);
  logic                  in_win, ok;
  logic [LINE_AW-1:0]    line;
  logic [LANE_W-1:0]     lane, lane_q;
  logic [1:0]            size_q;
  logic [LINE_BYTES-1:0] be;
  logic [LINE_W-1:0]     wline, rline;

  ocw_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE),
    .PAGE_AW(PAGE_AW), .LANE_W(LANE_W)
  ) u_dec (
    .addr_i(addr_i), .size_i(size_i), .cache_en_i(cache_en_i),
    .ram_mode_i(ram_mode_i), .split_mode_i(split_mode_i),
    .in_win_o(in_win), .ok_o(ok), .line_o(line), .lane_o(lane)
  );

  ocw_wpack #(.LINE_BYTES(LINE_BYTES)) u_wp (
    .size_i(size_i), .lane_i(lane), .wdata_i(wdata_i),
    .bwdata_i(bwdata_i), .be_o(be), .line_o(wline)
  );

  ocw_ram #(.LINE_BYTES(LINE_BYTES), .LINE_AW(LINE_AW)) u_ram (
    .clk(clk), .we_i(req_i && we_i && ok), .re_i(req_i && !we_i && ok),
    .addr_i(line), .be_i(be), .wline_i(wline), .rline_o(rline)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o <= 1'b0;
      ack_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      sel_o <= req_i && in_win;
      ack_o <= req_i && ok;
      err_o <= req_i && in_win && !ok;
    end
    if (req_i) begin
      size_q <= size_i;
      lane_q <= lane;
    end
  end

  ocw_rext #(.LINE_BYTES(LINE_BYTES)) u_rx (
    .size_i(size_q), .lane_i(lane_q), .line_i(rline), .rdata_o(rdata_o)
  );
  assign brdata_o = rline;

  // R1: requests outside the window stay silent
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_i && addr_i[ADDR_W-1:WIN_BITS] != WIN_BASE[ADDR_W-1:WIN_BITS])
    |=> (!sel_o && !ack_o && !err_o));

  // R2: disabled window reports an error
  a_r2_disabled_err: assert property (@(posedge clk) disable iff (rst)
    (req_i && addr_i[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]
     && !(cache_en_i && ram_mode_i)) |=> (err_o && sel_o && !ack_o));

  // R9: misaligned long access is rejected
  a_r9_misaligned_long: assert property (@(posedge clk) disable iff (rst)
    (req_i && size_i == 2'd2 && addr_i[1:0] != 2'b00 &&
     addr_i[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]) |=> err_o);

  // R10: no response without a request
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!sel_o && !ack_o && !err_o));

  // R10: completion and error are exclusive, and both imply a window hit
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    (ack_o || err_o) |-> (sel_o && !(ack_o && err_o)));
endmodule

// File: tb/tb_ocram_window.sv
module tb_ocram_window;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [2:0]  md;   // {cache_en, ram_mode, split_mode}
    logic        xs;
    logic        xe;
    logic [31:0] xr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 32'h7C000010, 32'h8899AABB, 3'b110, 1'b1, 1'b0, 32'h0,        4'd6},  // R6 long write
    '{1'b0, 2'd2, 32'h7C000010, 32'h0,        3'b110, 1'b1, 1'b0, 32'h8899AABB, 4'd6},  // R6
    '{1'b0, 2'd0, 32'h7C000013, 32'h0,        3'b110, 1'b1, 1'b0, 32'hFFFFFF88, 4'd7},  // R7
    '{1'b0, 2'd0, 32'h7C000010, 32'h0,        3'b110, 1'b1, 1'b0, 32'hFFFFFFBB, 4'd7},  // R7
    '{1'b0, 2'd1, 32'h7C000010, 32'h0,        3'b110, 1'b1, 1'b0, 32'hFFFFAABB, 4'd7},  // R7
    '{1'b1, 2'd1, 32'h7C000012, 32'h00001234, 3'b110, 1'b1, 1'b0, 32'h0,        4'd6},  // R6 word write
    '{1'b0, 2'd2, 32'h7C000010, 32'h0,        3'b110, 1'b1, 1'b0, 32'h1234AABB, 4'd6},  // R6
    '{1'b0, 2'd1, 32'h7C000012, 32'h0,        3'b110, 1'b1, 1'b0, 32'h00001234, 4'd7},  // R7 positive
    '{1'b1, 2'd0, 32'h7C002005, 32'h0000007F, 3'b110, 1'b1, 1'b0, 32'h0,        4'd3},  // R3 page 1
    '{1'b0, 2'd0, 32'h7C00A005, 32'h0,        3'b110, 1'b1, 1'b0, 32'h0000007F, 4'd3},  // R3 alias
    '{1'b0, 2'd0, 32'h7E000005, 32'h0,        3'b111, 1'b1, 1'b0, 32'h0000007F, 4'd4},  // R4 upper half
    '{1'b0, 2'd2, 32'h7C003010, 32'h0,        3'b111, 1'b1, 1'b0, 32'h1234AABB, 4'd5},  // R5 bit 13 ignored
    '{1'b0, 2'd2, 32'h7C004010, 32'h0,        3'b110, 1'b1, 1'b0, 32'h1234AABB, 4'd3},  // R3 page 0 alias
    '{1'b1, 2'd2, 32'h80000010, 32'hDEADBEEF, 3'b110, 1'b0, 1'b0, 32'h0,        4'd1},  // R1
    '{1'b1, 2'd2, 32'h7C000010, 32'h0,        3'b100, 1'b1, 1'b1, 32'h0,        4'd2},  // R2 ram off
    '{1'b1, 2'd2, 32'h7C000010, 32'h0,        3'b010, 1'b1, 1'b1, 32'h0,        4'd2},  // R2 cache off
    '{1'b1, 2'd2, 32'h7C000012, 32'h0,        3'b110, 1'b1, 1'b1, 32'h0,        4'd9},  // R9 long
    '{1'b1, 2'd1, 32'h7C000011, 32'h0,        3'b110, 1'b1, 1'b1, 32'h0,        4'd9},  // R9 word
    '{1'b0, 2'd2, 32'h7C000010, 32'h0,        3'b110, 1'b1, 1'b0, 32'h1234AABB, 4'd9},  // R9 R2 R1 untouched
    '{1'b0, 2'd2, 32'h7BFFFFF0, 32'h0,        3'b110, 1'b0, 1'b0, 32'h0,        4'd1}   // R1 below window
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req = 1'b0, we = 1'b0;
  logic [1:0]   sz = 2'd0;
  logic [31:0]  addr = '0, wd = '0;
  logic [255:0] bw = '0;
  logic         en = 1'b1, ramm = 1'b1, split = 1'b0;
  logic         sel, ack, err;
  logic [31:0]  rd;
  logic [255:0] brd;
  int           nchk = 0, nbad = 0;

  always #(PERIOD/2) clk = ~clk;

  ocram_window dut (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .size_i(sz), .addr_i(addr),
    .wdata_i(wd), .bwdata_i(bw), .cache_en_i(en), .ram_mode_i(ramm),
    .split_mode_i(split), .sel_o(sel), .ack_o(ack), .err_o(err),
    .rdata_o(rd), .brdata_o(brd)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] s, input logic [31:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; sz = s; addr = a; wd = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset flags", {253'd0, sel, ack, err}, 256'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {en, ramm, split} = VECS[i].md;
      access(VECS[i].we, VECS[i].sz, VECS[i].addr, VECS[i].wd);
      nchk++;
      if (sel !== VECS[i].xs || err !== VECS[i].xe || ack !== (VECS[i].xs && !VECS[i].xe) ||
          (!VECS[i].we && VECS[i].xs && !VECS[i].xe && rd !== VECS[i].xr)) begin
        nbad++;
        $display("FAIL R%0d vec %0d actual sel=%b ack=%b err=%b rd=%h expected sel=%b err=%b rd=%h",
                 VECS[i].rq, i, sel, ack, err, rd, VECS[i].xs, VECS[i].xe, VECS[i].xr);
      end
    end

    {en, ramm, split} = 3'b110;
    for (int k = 0; k < 32; k++) bw[8*k +: 8] = 8'(k + 1);
    access(1'b1, 2'd3, 32'h7C000100, 32'h0);
    check("R8 burst write ack", {255'd0, ack}, 256'd1);
    bw = '0;
    access(1'b0, 2'd3, 32'h7C000100, 32'h0);
    begin
      logic [255:0] expb;
      for (int k = 0; k < 32; k++) expb[8*k +: 8] = 8'(k + 1);
      check("R8 burst read", brd, expb);
    end
    access(1'b0, 2'd0, 32'h7C00011F, 32'h0);
    check("R8 last burst byte", {224'd0, rd}, 256'h20);
    access(1'b0, 2'd2, 32'h7C000104, 32'h0);
    check("R6 long in burst line", {224'd0, rd}, 256'h08070605);
    access(1'b1, 2'd3, 32'h7C000108, 32'h0);
    check("R9 misaligned burst", {254'd0, ack, err}, 256'd1);
    @(negedge clk);
    check("R10 pulse ends", {253'd0, sel, ack, err}, 256'd0);
    access(1'b0, 2'd3, 32'h7C000100, 32'h0);
    check("R9 burst untouched", brd[63:0], 64'h0807060504030201);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule